// File: doc/BRIEF.md
# Switch-on-Miss Thread Context Controller

This block steers an in-order pipeline that holds several hardware thread contexts, only one of which fetches at a time. The active thread runs until it takes a long-latency cache miss. On that miss the controller records the PC of the missing instruction as the thread's restart point and marks the thread as waiting. It then flushes the pipeline, holds issue for a fixed number of cycles and hands fetch to another thread that is not waiting.

Each thread context keeps a restart PC and a waiting flag. The memory side raises a per-thread return bit when a miss has been serviced, which makes that thread eligible to run again. The next thread is found by scanning upward from the thread just switched out, wrapping around, with the switched-out thread itself considered last. If no thread is eligible, the pipeline stays stalled until a return arrives. The fetch PC is produced here. While a thread runs without a miss, the fetch PC steps forward by a fixed instruction size each cycle. Caches, memory and the datapath are outside the block.

Top module: `miss_switch_ctrl`

## Requirements
- R1: After reset, thread 0 is active and the fetch PC is `BOOT_BASE`. Stall and flush are low and no thread is waiting. Each thread i has restart PC `BOOT_BASE + i*BOOT_STRIDE`.
- R2: In each cycle the controller is running (stall low) and no miss is presented, the next cycle's fetch PC is the current one plus `PC_STEP`, and the active thread does not change.
- R3: A miss presented while running gives a flush pulse lasting exactly one cycle, in the next cycle. The presented miss PC becomes the active thread's restart PC, and that thread becomes waiting.
- R4: After a miss, stall is high for exactly `FLUSH_CYCLES` cycles, starting with the flush-pulse cycle. It stays high longer only when no thread is eligible (R8).
- R5: At the end of the flush, the new active thread is the first non-waiting thread in the order current+1, current+2, … wrapping, with the current thread checked last. The fetch PC becomes that thread's restart PC.
- R6: A return bit for thread i clears thread i's waiting flag in any state. A return bit for a thread that is not waiting has no effect.
- R7: A miss presented while stall is high (during a flush or while all threads wait) is ignored. It changes no restart PC, marks no thread waiting and produces no flush pulse.
- R8: If every thread is waiting when the flush ends, stall stays high and flush stays low. In the cycle after one or more returns arrive, the controller runs the thread chosen by the R5 order, from its restart PC.
- R9: A return that arrives in the last flush cycle is counted in that cycle's choice. This includes a return for the thread just switched out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Active thread's fetch/load took a long-latency miss this cycle |
| miss_pc_i | input | PC_W | PC of the instruction that missed |
| miss_ret_i | input | NUM_THREADS | Per-thread miss-serviced indication, bit i for thread i |
| active_tid_o | output | TID_W | Thread currently owning fetch |
| fetch_pc_o | output | PC_W | PC to fetch this cycle |
| flush_o | output | 1 | One-cycle pulse: discard all in-flight instructions |
| stall_o | output | 1 | High while no instruction may issue (flush window or all threads waiting) |

## Verification
The bench builds the block with four thread contexts, a four-cycle flush, a 4-byte step and a 0x100 stride between boot PCs. With these values the pick order can wrap from thread 3 back to thread 0, and every context can be waiting at once, which produces the all-waiting stall. The four-cycle window leaves room to place an ignored miss in an inner flush cycle and a return in the final cycle. A behavioural model running in parallel predicts every output on every cycle. It sees directed switch chains and then several hundred cycles of random misses and returns.

// File: rtl/msc_pkg.sv
package msc_pkg;

    typedef enum logic [1:0] {
        CTL_RUN   = 2'd0,
        CTL_FLUSH = 2'd1,
        CTL_IDLE  = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/thread_ctx_table.sv
module thread_ctx_table #(
    parameter int              NUM_THREADS = 4,
    parameter int              PC_W        = 32,
    parameter logic [PC_W-1:0] BOOT_BASE   = 'h1000,
    parameter logic [PC_W-1:0] BOOT_STRIDE = 'h100,
    localparam int             TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   park_en_i,
    input  logic [TID_W-1:0]       park_tid_i,
    input  logic [PC_W-1:0]        park_pc_i,
    input  logic [NUM_THREADS-1:0] wake_i,
    input  logic [TID_W-1:0]       rd_tid_i,
    output logic [PC_W-1:0]        rd_pc_o,
    output logic [NUM_THREADS-1:0] waiting_o
);

    typedef struct packed {
        logic [NUM_THREADS-1:0][PC_W-1:0] pc;
        logic [NUM_THREADS-1:0]           waiting;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d         = ctx_q;
        ctx_d.waiting = ctx_q.waiting & ~wake_i;
        if (park_en_i) begin
            ctx_d.pc[park_tid_i]      = park_pc_i;
            ctx_d.waiting[park_tid_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_THREADS; i++) begin
                ctx_q.pc[i] <= BOOT_BASE + PC_W'(i) * BOOT_STRIDE;
            end
            ctx_q.waiting <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign rd_pc_o   = ctx_q.pc[rd_tid_i];
    assign waiting_o = ctx_q.waiting;

    // R3
    park_sets_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        park_en_i |=> waiting_o[$past(park_tid_i)]);

    // R6
    wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_i[0] && !(park_en_i && park_tid_i == '0)) |=> !waiting_o[0]);

endmodule

// File: rtl/next_thread_pick.sv
module next_thread_pick #(
    parameter int  NUM_THREADS = 4,
    localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic [TID_W-1:0]       cur_tid_i,
    input  logic [NUM_THREADS-1:0] ready_i,
    output logic                   found_o,
    output logic [TID_W-1:0]       pick_o
);

    always_comb begin
        found_o = 1'b0;
        pick_o  = cur_tid_i;
        for (int k = 1; k <= NUM_THREADS; k++) begin
            int idx;
            idx = (int'(cur_tid_i) + k) % NUM_THREADS;
            if (!found_o && ready_i[idx]) begin
                found_o = 1'b1;
                pick_o  = TID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/miss_switch_ctrl.sv
module miss_switch_ctrl
    import msc_pkg::*;
#(
    parameter int              NUM_THREADS  = 4,
    parameter int              PC_W         = 32,
    parameter int              FLUSH_CYCLES = 4,
    parameter logic [PC_W-1:0] PC_STEP      = 'h4,
    parameter logic [PC_W-1:0] BOOT_BASE    = 'h1000,
    parameter logic [PC_W-1:0] BOOT_STRIDE  = 'h100,
    localparam int             TID_W        = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int             CNT_W        = $clog2(FLUSH_CYCLES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   miss_valid_i,
    input  logic [PC_W-1:0]        miss_pc_i,
    input  logic [NUM_THREADS-1:0] miss_ret_i,
    output logic [TID_W-1:0]       active_tid_o,
    output logic [PC_W-1:0]        fetch_pc_o,
    output logic                   flush_o,
    output logic                   stall_o
);

    typedef struct packed {
        ctl_state_e       state;
        logic [CNT_W-1:0] left;
        logic [TID_W-1:0] tid;
        logic [PC_W-1:0]  pc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                   park_en;
    logic [NUM_THREADS-1:0] waiting;
    logic [NUM_THREADS-1:0] ready;
    logic                   pick_found;
    logic [TID_W-1:0]       pick_tid;
    logic [PC_W-1:0]        pick_pc;

    thread_ctx_table #(
        .NUM_THREADS (NUM_THREADS),
        .PC_W        (PC_W),
        .BOOT_BASE   (BOOT_BASE),
        .BOOT_STRIDE (BOOT_STRIDE)
    ) ctx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .park_en_i  (park_en),
        .park_tid_i (ctl_q.tid),
        .park_pc_i  (miss_pc_i),
        .wake_i     (miss_ret_i),
        .rd_tid_i   (pick_tid),
        .rd_pc_o    (pick_pc),
        .waiting_o  (waiting)
    );

    // returns arriving this cycle already count for the choice
    assign ready = ~(waiting & ~miss_ret_i);

    next_thread_pick #(
        .NUM_THREADS (NUM_THREADS)
    ) pick_i (
        .cur_tid_i (ctl_q.tid),
        .ready_i   (ready),
        .found_o   (pick_found),
        .pick_o    (pick_tid)
    );

    always_comb begin
        ctl_d   = ctl_q;
        park_en = 1'b0;
        unique case (ctl_q.state)
            CTL_RUN: begin
                if (miss_valid_i) begin
                    park_en     = 1'b1;
                    ctl_d.state = CTL_FLUSH;
                    ctl_d.left  = CNT_W'(FLUSH_CYCLES);
                end else begin
                    ctl_d.pc = ctl_q.pc + PC_STEP;
                end
            end
            CTL_FLUSH, CTL_IDLE: begin
                if (ctl_q.state == CTL_FLUSH && ctl_q.left != CNT_W'(1)) begin
                    ctl_d.left = ctl_q.left - CNT_W'(1);
                end else if (pick_found) begin
                    ctl_d.state = CTL_RUN;
                    ctl_d.tid   = pick_tid;
                    ctl_d.pc    = pick_pc;
                    ctl_d.left  = '0;
                end else begin
                    ctl_d.state = CTL_IDLE;
                    ctl_d.left  = '0;
                end
            end
            default: ctl_d.state = CTL_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= CTL_RUN;
            ctl_q.left  <= '0;
            ctl_q.tid   <= '0;
            ctl_q.pc    <= BOOT_BASE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign active_tid_o = ctl_q.tid;
    assign fetch_pc_o   = ctl_q.pc;
    assign stall_o      = (ctl_q.state != CTL_RUN);
    assign flush_o      = (ctl_q.state == CTL_FLUSH) && (ctl_q.left == CNT_W'(FLUSH_CYCLES));

    // R3
    miss_then_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && miss_valid_i) |=> flush_o);

    // R4
    flush_holds_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> stall_o);

    // R7
    no_flush_from_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !flush_o);

    // R5
    switch_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_tid_o) |-> $past(stall_o));

    // R5
    runner_not_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_o |-> !waiting[active_tid_o]);

    // R2
    step_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && !miss_valid_i) |=> (fetch_pc_o == $past(fetch_pc_o) + PC_STEP));

endmodule

// File: tb/miss_switch_ctrl_tb_top.sv
module miss_switch_ctrl_tb_top;

    localparam int          NT     = 4;
    localparam int          PCW    = 32;
    localparam int          FC     = 4;
    localparam logic [31:0] STEP   = 32'h4;
    localparam logic [31:0] BASE   = 32'h1000;
    localparam logic [31:0] STRIDE = 32'h100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [31:0]   miss_pc = '0;
    logic [NT-1:0] miss_ret = '0;
    logic [1:0]    active_tid;
    logic [31:0]   fetch_pc;
    logic          flush;
    logic          stall;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    miss_switch_ctrl #(
        .NUM_THREADS  (NT),
        .PC_W         (PCW),
        .FLUSH_CYCLES (FC),
        .PC_STEP      (STEP),
        .BOOT_BASE    (BASE),
        .BOOT_STRIDE  (STRIDE)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_valid_i (miss_valid),
        .miss_pc_i    (miss_pc),
        .miss_ret_i   (miss_ret),
        .active_tid_o (active_tid),
        .fetch_pc_o   (fetch_pc),
        .flush_o      (flush),
        .stall_o      (stall)
    );

    // behavioural reference: mode 0 running, 1 flushing, 2 all waiting
    int          m_mode = 0;
    int          m_left = 0;
    int          m_act  = 0;
    logic [31:0] m_pc   = BASE;
    logic [31:0] m_rst_pc [NT];
    bit          m_wait [NT];

    task automatic m_reset();
        m_mode = 0; m_left = 0; m_act = 0; m_pc = BASE;
        for (int i = 0; i < NT; i++) begin
            m_rst_pc[i] = BASE + 32'(i) * STRIDE;
            m_wait[i]   = 1'b0;
        end
    endtask

    task automatic m_choose();
        bit got = 1'b0;
        for (int k = 1; k <= NT; k++) begin
            int c = (m_act + k) % NT;
            if (!got && !m_wait[c]) begin
                got = 1'b1; m_act = c; m_pc = m_rst_pc[c]; m_mode = 0;
            end
        end
        if (!got) m_mode = 2;
    endtask

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            for (int i = 0; i < NT; i++) if (miss_ret[i]) m_wait[i] = 1'b0;
            if (m_mode == 0) begin
                if (miss_valid) begin
                    m_rst_pc[m_act] = miss_pc;
                    m_wait[m_act]   = 1'b1;
                    m_mode = 1;
                    m_left = FC;
                end else begin
                    m_pc = m_pc + STEP;
                end
            end else if (m_mode == 1 && m_left != 1) begin
                m_left = m_left - 1;
            end else begin
                m_choose();
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_all(string tag);
        chk({tag, " active_tid"}, 64'(active_tid), 64'(m_act));
        chk({tag, " fetch_pc"}, 64'(fetch_pc), 64'(m_pc));
        chk({tag, " stall"}, 64'(stall), 64'(m_mode != 0));
        chk({tag, " flush"}, 64'(flush), 64'(m_mode == 1 && m_left == FC));
    endtask

    // every-cycle comparison: R5 thread, R2 PC, R4 stall, R3 flush
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 cycle active_tid", 64'(active_tid), 64'(m_act));
            chk("R2 cycle fetch_pc", 64'(fetch_pc), 64'(m_pc));
            chk("R4 cycle stall", 64'(stall), 64'(m_mode != 0));
            chk("R3 cycle flush", 64'(flush), 64'(m_mode == 1 && m_left == FC));
        end
    end

    task automatic drive(bit mv, logic [31:0] pc, logic [NT-1:0] ret);
        miss_valid = mv; miss_pc = pc; miss_ret = ret;
        @(negedge clk);
        miss_valid = 1'b0; miss_pc = '0; miss_ret = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, '0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 active_tid", 64'(active_tid), 64'd0);
        chk("R1 fetch_pc", 64'(fetch_pc), 64'(BASE));
        chk("R1 stall", 64'(stall), 64'd0);
        chk("R1 flush", 64'(flush), 64'd0);
        idle(3);
        chk("R2 step", 64'(fetch_pc), 64'(BASE + 3 * STEP));

        // R3 miss on thread 0
        drive(1'b1, 32'h2000, '0);
        chk("R3 flush pulse", 64'(flush), 64'd1);
        // R7 miss inside the flush window is ignored
        drive(1'b1, 32'hdead, '0);
        chk_all("R7 during flush");
        idle(3);
        // R4 stall ended, R5 thread 1 from its boot PC
        chk("R5 to t1", 64'(active_tid), 64'd1);
        chk("R5 t1 pc", 64'(fetch_pc), 64'(BASE + STRIDE));
        idle(3);
        drive(1'b1, 32'h3000, '0);
        idle(4);
        chk("R5 to t2", 64'(active_tid), 64'd2);
        idle(2);
        drive(1'b1, 32'h4000, '0);
        idle(4);
        chk("R5 to t3", 64'(active_tid), 64'd3);
        idle(2);
        drive(1'b1, 32'h5000, '0);
        idle(4);
        // R8 every thread waiting
        chk("R8 stall held", 64'(stall), 64'd1);
        drive(1'b1, 32'hbeef, '0);
        idle(2);
        chk_all("R7 during idle");
        drive(1'b0, '0, 4'b0100);
        chk("R8 resume t2", 64'(active_tid), 64'd2);
        chk("R8 resume pc", 64'(fetch_pc), 64'h4000);

        // R6 returns while running
        drive(1'b0, '0, 4'b1011);
        idle(2);
        drive(1'b1, 32'h6000, '0);
        idle(4);
        chk("R5 after t2 picks t3", 64'(active_tid), 64'd3);
        chk("R6 t3 restart pc", 64'(fetch_pc), 64'h5000);
        // R6 return for a non-waiting thread has no effect
        drive(1'b0, '0, 4'b0010);
        drive(1'b1, 32'h7000, '0);
        idle(4);
        chk("R5 wrap to t0", 64'(active_tid), 64'd0);
        chk("R7 t0 restart pc kept", 64'(fetch_pc), 64'h2000);

        // R9 return of switched-out thread in final flush cycle
        idle(1);
        drive(1'b1, 32'h8000, '0);
        idle(4);
        chk("R5 to t1 again", 64'(active_tid), 64'd1);
        idle(1);
        drive(1'b1, 32'h9000, '0);
        idle(3);
        drive(1'b0, '0, 4'b0010);
        chk("R9 self pick", 64'(active_tid), 64'd1);
        chk("R9 self pc", 64'(fetch_pc), 64'h9000);
        chk("R9 stall", 64'(stall), 64'd0);

        // random traffic
        for (int i = 0; i < 500; i++) begin
            bit            mv = ($urandom_range(0, 5) == 0);
            logic [NT-1:0] r  = '0;
            for (int t = 0; t < NT; t++) r[t] = ($urandom_range(0, 9) == 0);
            drive(mv, $urandom & 32'hffff_fffc, r);
        end
        idle(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule